// File: doc/BRIEF.md
# Edge-Triggered Finite Burst Sampler

This block runs one analog input acquisition channel on its own schedule. It watches a digital trigger line. On each rising edge that arrives while the channel is idle, it asks an external converter for a programmed number of samples, one at a time. Successive requests are spaced by a programmed interval given in microseconds. A free-running system clock (40 MHz by default) is divided into microsecond units by an internal timer. Each returned 16-bit two's-complement sample is widened to a 32-bit word and offered at once to a streaming FIFO port with a valid/ready handshake.

The sample count and the interval come from configuration inputs that a host register file drives. Both values are captured when a burst starts. A busy output shows whether a burst is running. Two sticky flags record lost trigger edges and lost samples, and only reset clears them. The block keeps no state shared with other copies, so several instances can each sample at their own rate and burst length.

The controller is a three-state machine. `ST_IDLE` waits for a trigger. `ST_REQ` holds the converter request. `ST_GAP` waits out the rest of the interval. The transitions are:
- *start*: `ST_IDLE` to `ST_REQ`, on a synchronized rising edge when the count is nonzero.
- *sample*: `ST_REQ` to `ST_GAP`, on an acknowledge that is not the last one of the burst.
- *finish*: `ST_REQ` to `ST_IDLE`, on the last acknowledge of the burst.
- *next*: `ST_GAP` to `ST_REQ`, when the interval has elapsed.

Top module: `burst_sampler`

## Requirements
- R1: After reset, `busy`, `conv_req`, `fifo_valid`, `overrun` and `overflow` are all 0.
- R2: `trig_in` passes through a two-flop synchronizer. When `trig_in` goes high between two clock edges, `conv_req` and `busy` are 1 after the third rising edge that follows, and 0 after the second.
- R3: Each `conv_ack` sampled while `conv_req` is high yields exactly one FIFO offer. `fifo_valid` is 1 for the single cycle after that edge. `fifo_data` carries the sample in bits 15:0, and bits 31:16 are copies of sample bit 15.
- R4: `conv_req` stays high until an edge at which `conv_ack` is 1, and is low after that edge.
- R5: A burst issues exactly `cfg_count` requests. The count and the period are captured at the start of the burst, and changes to them during the burst have no effect. `busy` falls at the edge that accepts the last acknowledge.
- R6: Consecutive rises of `conv_req` within a burst are exactly `cfg_period` × CLK_PER_US clock cycles apart, whenever each conversion completes within that time. When a conversion takes longer, the next request rises two edges after the acknowledge.
- R7: A trigger edge seen while `cfg_count` is 0 starts nothing: `busy` and `conv_req` stay 0.
- R8: A trigger edge that arrives while a burst runs does not restart or lengthen the burst. It sets `overrun`, which stays 1 until reset.
- R9: A word offered while `fifo_ready` is 0 is dropped, and the burst continues. This sets `overflow`, which stays 1 until reset.
- R10: Two instances triggered in the same cycle with different counts and periods each produce their own count and spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger line |
| cfg_count | input | CNT_W | Samples per burst (0 disables) |
| cfg_period | input | PER_W | Sample interval in microseconds |
| busy | output | 1 | Burst in progress |
| overrun | output | 1 | Sticky: a trigger was ignored during a burst |
| overflow | output | 1 | Sticky: a sample was dropped at the FIFO port |
| conv_req | output | 1 | Conversion request, held until acknowledged |
| conv_ack | input | 1 | Converter acknowledge, one-cycle pulse |
| conv_data | input | SMP_W | Signed sample, valid with `conv_ack` |
| fifo_valid | output | 1 | FIFO word offered (one cycle) |
| fifo_data | output | WORD_W | Sign-extended sample word |
| fifo_ready | input | 1 | FIFO can accept a word |

## Verification
The channel is run through single-sample and multi-sample bursts with short and long periods. These runs separate a correct request count from an off-by-one burst length, and exact cycle spacing from a timer that drifts by a cycle. The converter model returns samples of both signs, which exposes any fault in the sign widening. A mid-burst retrigger, a mid-burst configuration change, a zero count and a FIFO held not ready each aim at one rule of R5 to R9. A final run starts two instances together with different settings, which shows whether one channel's schedule leaks into the other.

// File: rtl/burst_sampler_pkg.sv
package burst_sampler_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } bs_state_e;
endpackage

// File: rtl/bs_trig_sync.sv
module bs_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

    // A detected edge cannot persist beyond one cycle.
    a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/bs_us_timer.sv
module bs_us_timer #(
    parameter int CLK_PER_US = 40,
    parameter int LIM_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             done_o
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    logic [LIM_W-1:0] us_q;
    logic             us_max;

    assign us_max = (us_q == {LIM_W{1'b1}});

    generate
        if (CLK_PER_US == 1) begin : g_direct
            always_ff @(posedge clk) begin
                if (!rst_n)       us_q <= '0;
                else if (clear_i) us_q <= LIM_W'(1);
                else if (!us_max) us_q <= us_q + 1'b1;
            end
        end else begin : g_prescale
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);
            logic [PRE_W-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                    us_q  <= '0;
                end else if (clear_i) begin
                    pre_q <= PRE_W'(1);
                    us_q  <= '0;
                end else if (pre_q == PRE_LAST) begin
                    pre_q <= '0;
                    if (!us_max) us_q <= us_q + 1'b1;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    endgenerate

    assign done_o = (us_q >= limit_i);

    // The elapsed count never moves backwards except on clear.
    a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (us_q >= $past(us_q)));
endmodule

// File: rtl/bs_push_stage.sv
module bs_push_stage #(
    parameter int SMP_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [SMP_W-1:0]  sample_i,
    input  logic              fifo_ready,
    output logic              fifo_valid,
    output logic [WORD_W-1:0] fifo_data,
    output logic              overflow_o
);
    localparam int EXT_W = WORD_W - SMP_W;

    logic [WORD_W-1:0] word_d;

    assign word_d = {{EXT_W{sample_i[SMP_W-1]}}, sample_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_valid <= 1'b0;
            fifo_data  <= '0;
        end else begin
            fifo_valid <= push_i;
            if (push_i) fifo_data <= word_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         overflow_o <= 1'b0;
        else if (fifo_valid && !fifo_ready) overflow_o <= 1'b1;
    end

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
    a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_valid && !fifo_ready) |=> overflow_o);
endmodule

// File: rtl/burst_sampler.sv
module burst_sampler
    import burst_sampler_pkg::*;
#(
    parameter int CLK_PER_US  = 40,
    parameter int CNT_W       = 16,
    parameter int PER_W       = 16,
    parameter int SMP_W       = 16,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [PER_W-1:0]  cfg_period,
    output logic              busy,
    output logic              overrun,
    output logic              overflow,
    output logic              conv_req,
    input  logic              conv_ack,
    input  logic [SMP_W-1:0]  conv_data,
    output logic              fifo_valid,
    output logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_ready
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    bs_state_e        state_q, state_d;
    logic [CNT_W-1:0] remain_q;
    logic [PER_W-1:0] period_q;
    logic             trig_rise;
    logic             gap_done;
    logic             load_cfg;
    logic             timer_clr;
    logic             push;

    bs_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (trig_in),
        .rise_o  (trig_rise)
    );

    bs_us_timer #(.CLK_PER_US(CLK_PER_US), .LIM_W(PER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (timer_clr),
        .limit_i (period_q),
        .done_o  (gap_done)
    );

    bs_push_stage #(.SMP_W(SMP_W), .WORD_W(WORD_W)) u_push (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .sample_i   (conv_data),
        .fifo_ready (fifo_ready),
        .fifo_valid (fifo_valid),
        .fifo_data  (fifo_data),
        .overflow_o (overflow)
    );

    // next-state and control strobes
    always_comb begin
        state_d   = state_q;
        load_cfg  = 1'b0;
        timer_clr = 1'b0;
        push      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_rise && (cfg_count != '0)) begin
                    load_cfg  = 1'b1;
                    timer_clr = 1'b1;
                    state_d   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (conv_ack) begin
                    push    = 1'b1;
                    state_d = (remain_q == CNT_ONE) ? ST_IDLE : ST_GAP;
                end
            end
            ST_GAP: begin
                if (gap_done) begin
                    timer_clr = 1'b1;
                    state_d   = ST_REQ;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst parameters captured at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            period_q <= '0;
        end else if (load_cfg) begin
            remain_q <= cfg_count;
            period_q <= cfg_period;
        end else if (push) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // sticky lost-trigger flag
    always_ff @(posedge clk) begin
        if (!rst_n)                               overrun <= 1'b0;
        else if (trig_rise && state_q != ST_IDLE) overrun <= 1'b1;
    end

    // outputs
    always_comb begin
        conv_req = (state_q == ST_REQ);
        busy     = (state_q != ST_IDLE);
    end

    a_r2_start_requests: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> conv_req);
    a_r3_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_valid |-> $past(conv_ack));
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_ack) |=> conv_req);
    a_r5_end_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(conv_ack));
    a_r7_zero_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig_rise && cfg_count == '0) |=> !busy);
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

// File: tb/burst_sampler_tb_top.sv
module burst_sampler_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 4;
    localparam int LAT_A      = 2;
    localparam int LAT_B      = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic        trig_a = 1'b0, trig_b = 1'b0;
    logic [15:0] cnt_a = '0, cnt_b = '0, per_a = '0, per_b = '0;
    logic        busy_a, busy_b, ovr_a, ovr_b, ovf_a, ovf_b;
    logic        req_a, req_b, ack_a = 1'b0, ack_b = 1'b0;
    logic [15:0] dat_a = '0, dat_b = '0;
    logic        val_a, val_b, rdy_a = 1'b1, rdy_b = 1'b1;
    logic [31:0] word_a, word_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_sampler #(.CLK_PER_US(CPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_a), .cfg_count(cnt_a), .cfg_period(per_a),
        .busy(busy_a), .overrun(ovr_a), .overflow(ovf_a), .conv_req(req_a), .conv_ack(ack_a),
        .conv_data(dat_a), .fifo_valid(val_a), .fifo_data(word_a), .fifo_ready(rdy_a));

    burst_sampler #(.CLK_PER_US(CPU)) dut2_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_b), .cfg_count(cnt_b), .cfg_period(per_b),
        .busy(busy_b), .overrun(ovr_b), .overflow(ovf_b), .conv_req(req_b), .conv_ack(ack_b),
        .conv_data(dat_b), .fifo_valid(val_b), .fifo_data(word_b), .fifo_ready(rdy_b));

    int checks = 0, errors = 0, cyc = 0;
    int rise_n_a, word_n_a, offer_n_a, ack_n_a, rise_n_b, word_n_b;
    int rise_t_a[32], rise_t_b[32];
    logic [31:0] got_a[32];
    logic [15:0] exp_a[32];
    logic busy_seen_a, req_prev_a, req_prev_b;
    logic [15:0] next_a = 16'h7FF0, next_b = 16'h0100;

    initial forever begin @(posedge clk); cyc++; end

    // converter models
    initial begin : conv_a_model
        int w = 0;
        forever begin
            @(negedge clk);
            ack_a = 1'b0;
            if (req_a && w == LAT_A) begin
                ack_a = 1'b1; dat_a = next_a;
                if (ack_n_a < 32) exp_a[ack_n_a] = next_a;
                ack_n_a++; next_a = next_a + 16'hC3A7; w = 0;
            end else if (req_a) w++;
            else w = 0;
        end
    end
    initial begin : conv_b_model
        int w = 0;
        forever begin
            @(negedge clk);
            ack_b = 1'b0;
            if (req_b && w == LAT_B) begin
                ack_b = 1'b1; dat_b = next_b; next_b = next_b + 16'h0011; w = 0;
            end else if (req_b) w++;
            else w = 0;
        end
    end

    // monitor
    initial forever begin
        @(negedge clk);
        if (busy_a) busy_seen_a = 1'b1;
        if (req_a && !req_prev_a) begin
            if (rise_n_a < 32) rise_t_a[rise_n_a] = cyc;
            rise_n_a++;
        end
        if (req_b && !req_prev_b) begin
            if (rise_n_b < 32) rise_t_b[rise_n_b] = cyc;
            rise_n_b++;
        end
        req_prev_a = req_a; req_prev_b = req_b;
        if (val_a) offer_n_a++;
        if (val_a && rdy_a) begin
            if (word_n_a < 32) got_a[word_n_a] = word_a;
            word_n_a++;
        end
        if (val_b && rdy_b) word_n_b++;
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        rise_n_a = 0; word_n_a = 0; offer_n_a = 0; ack_n_a = 0;
        rise_n_b = 0; word_n_b = 0; busy_seen_a = 1'b0;
        req_prev_a = 1'b0; req_prev_b = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; trig_a = 1'b0; trig_b = 1'b0; rdy_a = 1'b1; rdy_b = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr_mon();
    endtask

    task automatic pulse_a();
        @(negedge clk); trig_a = 1'b1;
        repeat (3) @(negedge clk); trig_a = 1'b0;
    endtask

    task automatic wait_idle_a();
        int n = 0;
        while ((busy_a || busy_b) && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] sext(input logic [15:0] s);
        return {{16{s[15]}}, s};
    endfunction

    task automatic t_reset();
        apply_reset();
        check(!busy_a && !req_a && !val_a && !ovr_a && !ovf_a, "R1 reset outputs",
              {busy_a, req_a, val_a, ovr_a, ovf_a}, 0);
    endtask

    task automatic t_latency();
        int k = 0;
        logic held = 1'b1;
        apply_reset();
        cnt_a = 1; per_a = 3;
        @(negedge clk); trig_a = 1'b1;
        repeat (2) @(posedge clk); #1;
        check(!req_a && !busy_a, "R2 no request after two edges", req_a, 0);
        @(posedge clk); #1;
        check(req_a && busy_a, "R2 request after third edge", {busy_a, req_a}, 2'b11);
        trig_a = 1'b0;
        while (!ack_a && k < 50) begin @(negedge clk); if (!ack_a && !req_a) held = 1'b0; k++; end
        check(held, "R4 request held until ack", held, 1);
        @(posedge clk); #1;
        check(!req_a, "R4 request drops after ack", req_a, 0);
        check(val_a, "R3 valid cycle after ack", val_a, 1);
        check(!busy_a, "R5 busy falls on last ack", busy_a, 0);
        @(posedge clk); #1;
        check(!val_a, "R3 valid lasts one cycle", val_a, 0);
        wait_idle_a();
        check(word_n_a == 1, "R3 one word per ack", word_n_a, 1);
        check(got_a[0] == sext(exp_a[0]), "R3 sign-extended word", got_a[0], sext(exp_a[0]));
    endtask

    task automatic t_burst();
        apply_reset();
        cnt_a = 3; per_a = 5;
        pulse_a(); wait_idle_a();
        check(rise_n_a == 3, "R5 request count", rise_n_a, 3);
        check(word_n_a == 3, "R3 word count", word_n_a, 3);
        for (int i = 1; i < 3; i++)
            check(rise_t_a[i] - rise_t_a[i-1] == 5*CPU, "R6 spacing", rise_t_a[i] - rise_t_a[i-1], 5*CPU);
        for (int i = 0; i < 3; i++)
            check(got_a[i] == sext(exp_a[i]), "R3 sample data", got_a[i], sext(exp_a[i]));
        check(!ovr_a && !ovf_a, "R8 R9 flags clear", {ovr_a, ovf_a}, 0);
    endtask

    task automatic t_cfg_change();
        apply_reset();
        cnt_a = 4; per_a = 4;
        pulse_a();
        cnt_a = 1; per_a = 9;
        wait_idle_a();
        check(rise_n_a == 4, "R5 count captured at start", rise_n_a, 4);
        check(rise_t_a[3] - rise_t_a[2] == 4*CPU, "R5 period captured at start", rise_t_a[3] - rise_t_a[2], 4*CPU);
    endtask

    task automatic t_zero();
        apply_reset();
        cnt_a = 0; per_a = 2;
        pulse_a();
        repeat (20) @(negedge clk);
        check(!busy_seen_a && rise_n_a == 0, "R7 zero count starts nothing", rise_n_a, 0);
        check(!ovr_a, "R7 no overrun", ovr_a, 0);
    endtask

    task automatic t_retrig();
        apply_reset();
        cnt_a = 3; per_a = 6;
        pulse_a();
        repeat (10) @(negedge clk);
        check(!ovr_a, "R8 overrun clear before retrigger", ovr_a, 0);
        pulse_a();
        wait_idle_a();
        check(rise_n_a == 3, "R8 retrigger ignored", rise_n_a, 3);
        check(ovr_a, "R8 overrun sticky", ovr_a, 1);
    endtask

    task automatic t_overflow();
        apply_reset();
        rdy_a = 1'b0; cnt_a = 2; per_a = 3;
        pulse_a(); wait_idle_a();
        check(word_n_a == 0, "R9 no words accepted", word_n_a, 0);
        check(offer_n_a == 2, "R9 burst continues", offer_n_a, 2);
        check(ovf_a, "R9 overflow sticky", ovf_a, 1);
        rdy_a = 1'b1;
    endtask

    task automatic t_dual();
        apply_reset();
        cnt_a = 2; per_a = 7; cnt_b = 5; per_b = 2;
        @(negedge clk); trig_a = 1'b1; trig_b = 1'b1;
        repeat (3) @(negedge clk); trig_a = 1'b0; trig_b = 1'b0;
        wait_idle_a();
        check(rise_n_a == 2 && word_n_a == 2, "R10 channel A count", rise_n_a, 2);
        check(rise_n_b == 5 && word_n_b == 5, "R10 channel B count", rise_n_b, 5);
        check(rise_t_a[1] - rise_t_a[0] == 7*CPU, "R10 channel A spacing", rise_t_a[1] - rise_t_a[0], 7*CPU);
        check(rise_t_b[4] - rise_t_b[3] == 2*CPU, "R10 channel B spacing", rise_t_b[4] - rise_t_b[3], 2*CPU);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        clr_mon();
        t_reset();
        t_latency();
        t_burst();
        t_cfg_change();
        t_zero();
        t_retrig();
        t_overflow();
        t_dual();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule